// File: doc/BRIEF.md
# Fast-Channel Word Bank with Write Interrupts

This block holds a small set of channel words that a sender writes and a receiver reads, much like a RAM. The sender may overwrite a word whenever it likes. It does not have to wait for the receiver to pick up the earlier value, so older values can be lost and the newest one always wins. The sender gets nothing back from the receiver. Every accepted write also marks the channel as pending, which tells the receiver that something arrived.

The receiver sees each pending bit as a level interrupt, gated by a per-channel mask. It also sees a group interrupt for each run of `GRP_SIZE` neighbouring channels. The receiver reads words through a channel-select port. It clears pending bits by writing ones to a clear vector, and it loads the mask as a whole vector. The word width is a parameter, either 32 or 64 bits. The channel count is limited to 1024 for 32-bit words and to 512 for 64-bit words.

Top module: `fch_bank`

## Requirements
- R1: After reset, every word reads as zero, every pending bit and mask bit is 0, and every channel and group interrupt is low.
- R2: When `snd_we` is high with a valid `snd_ch`, `snd_data` is stored at that clock edge. From then on, `rcv_rd_data` shows it whenever `rcv_rd_ch` selects that channel; the read is combinational. Selecting an index of `NUM_CH` or above returns zero.
- R3: Writes to the same channel in back-to-back cycles leave only the last value readable. The pending bit stays set after the last of them.
- R4: An accepted write sets the channel's bit of `rcv_pend` at the same edge, whatever the bit held before.
- R5: A 1 in bit c of `rcv_clr` clears pending bit c at the edge. A 0 bit leaves its channel unchanged.
- R6: If a write and a clear reach the same channel in one cycle, the pending bit ends up set.
- R7: `rcv_ch_irq[c]` is high exactly when pending bit c is 1 and mask bit c is 0 (mask bit 1 means masked). A `rcv_mask_we` loads `rcv_mask_data` at the edge. The level holds until the pending bit is cleared or masked.
- R8: `rcv_grp_irq[g]` is the OR of `rcv_ch_irq` over channels g*GRP_SIZE up to g*GRP_SIZE+GRP_SIZE-1, cut off at `NUM_CH`, so the last group may be partial.
- R9: A write with `snd_ch` of `NUM_CH` or above is ignored. No word and no pending bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_we | input | 1 | Sender write strobe |
| snd_ch | input | CH_W | Sender channel index |
| snd_data | input | WORD_W | Sender word |
| rcv_rd_ch | input | CH_W | Receiver read channel select |
| rcv_rd_data | output | WORD_W | Word of the selected channel |
| rcv_clr | input | NUM_CH | Write-one-to-clear pending vector |
| rcv_mask_we | input | 1 | Load strobe for the mask |
| rcv_mask_data | input | NUM_CH | New mask value (1 = masked) |
| rcv_pend | output | NUM_CH | Raw pending bits |
| rcv_ch_irq | output | NUM_CH | Per-channel level interrupts |
| rcv_grp_irq | output | NUM_GRP | Group level interrupts |

## Verification
Two situations are hard to reach from the ports: a write and a clear hitting the same channel in the same cycle, and a write that uses an out-of-range index while a word and a pending bit that it could disturb are being watched. The random stimulus draws channel indices from the full select width, so about a quarter of all writes are out of range. Clear vectors are random, so they often overlap the written channel. Directed cycles then force each case once with known values and check every word and pending bit right after. The default channel count leaves the last group partial, so the cut-off group OR is exercised too.

// File: rtl/fch_pkg.sv
// fch_pkg: shared limits and helpers for the fast-channel bank.
// Assumes: word width is 32 or 64; channel limits depend on width.
package fch_pkg;
    localparam int FCH_LIMIT_W32 = 1024;
    localparam int FCH_LIMIT_W64 = 512;

    // Largest channel count allowed for a given word width.
    function automatic int fch_max_channels(input int word_w);
        return (word_w == 64) ? FCH_LIMIT_W64 : FCH_LIMIT_W32;
    endfunction

    // Width of a channel index able to address n channels.
    function automatic int fch_index_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of groups of size g covering n channels.
    function automatic int fch_group_count(input int n, input int g);
        return (n + g - 1) / g;
    endfunction
endpackage

// File: rtl/fch_wr_decode.sv
// fch_wr_decode: turns a sender write strobe and index into a one-hot hit
// vector. Assumes: indices at or above NUM_CH give no hit (R9).
module fch_wr_decode #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] hit
);
    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_hit
            localparam logic [CH_W-1:0] IDX = CH_W'(c);
            // One comparator per channel: hit when the index matches.
            always_comb hit[c] = we && (ch == IDX);
        end
    endgenerate

    // At most one channel is hit per write.
    p_single_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/fch_store.sv
// fch_store: the channel word array with last-write-wins update and a
// combinational read mux. Assumes: wr_hit is one-hot or zero.
module fch_store #(
    parameter int NUM_CH = 6,
    parameter int WORD_W = 32,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] word_q [NUM_CH];

    // Word update: reset to zero, otherwise overwrite on a hit.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n)
                word_q[c] <= '0;
            else if (wr_hit[c])
                word_q[c] <= wr_data;
        end
    end

    // Read mux: selected word, zero for out-of-range indices.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c))
                rd_data = word_q[c];
        end
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chk
            // Written value is held after the write edge.
            p_last_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[c] |=> (word_q[c] == $past(wr_data)));
            // Words not hit keep their value.
            p_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_hit[c] |=> $stable(word_q[c]));
        end
    endgenerate
endmodule

// File: rtl/fch_pending.sv
// fch_pending: sticky pending bits, mask register and per-channel level
// interrupts. Assumes: a write and a clear in one cycle leave the bit set.
module fch_pending #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] wr_hit,
    input  logic [NUM_CH-1:0] clr,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] mask_data,
    output logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] ch_irq
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] mask_q;

    // Pending update: clear first, then set wins on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | wr_hit;
    end

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= mask_data;
    end

    // Outputs: raw pending and gated interrupt levels.
    always_comb begin
        pend   = pend_q;
        ch_irq = pend_q & ~mask_q;
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chk
            p_set_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[c] |=> pend_q[c]);
            p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[c] && !wr_hit[c]) |=> !pend_q[c]);
            p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[c] && wr_hit[c]) |=> pend_q[c]);
            p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[c] && !clr[c]) |=> pend_q[c]);
        end
    endgenerate
endmodule

// File: rtl/fch_group.sv
// fch_group: ORs per-channel interrupts into groups of GRP_SIZE channels.
// Assumes: the last group may hold fewer channels.
module fch_group #(
    parameter int NUM_CH   = 6,
    parameter int GRP_SIZE = 4,
    parameter int NUM_GRP  = 2
) (
    input  logic [NUM_CH-1:0]  ch_irq,
    output logic [NUM_GRP-1:0] grp_irq
);
    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            localparam int LO = g * GRP_SIZE;
            localparam int HI = ((LO + GRP_SIZE) < NUM_CH) ? (LO + GRP_SIZE - 1) : (NUM_CH - 1);
            // Group level: any unmasked pending channel in the range.
            always_comb grp_irq[g] = |ch_irq[HI:LO];
        end
    endgenerate
endmodule

// File: rtl/fch_bank.sv
// fch_bank: top of the fast-channel word bank. The sender overwrites words
// freely; each accepted write raises a sticky pending level interrupt.
// Assumes: sender and receiver share clk; WORD_W is 32 or 64.
module fch_bank
    import fch_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int WORD_W   = 32,
    parameter int GRP_SIZE = 4,
    parameter int CH_W     = fch_index_width(NUM_CH),
    parameter int NUM_GRP  = fch_group_count(NUM_CH, GRP_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snd_we,
    input  logic [CH_W-1:0]    snd_ch,
    input  logic [WORD_W-1:0]  snd_data,
    input  logic [CH_W-1:0]    rcv_rd_ch,
    output logic [WORD_W-1:0]  rcv_rd_data,
    input  logic [NUM_CH-1:0]  rcv_clr,
    input  logic               rcv_mask_we,
    input  logic [NUM_CH-1:0]  rcv_mask_data,
    output logic [NUM_CH-1:0]  rcv_pend,
    output logic [NUM_CH-1:0]  rcv_ch_irq,
    output logic [NUM_GRP-1:0] rcv_grp_irq
);
    localparam int MAX_CH = fch_max_channels(WORD_W);

    generate
        if (!(WORD_W == 32 || WORD_W == 64)) begin : g_bad_width
            $error("fch_bank: WORD_W must be 32 or 64");
        end
        if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_count
            $error("fch_bank: NUM_CH outside the allowed range for WORD_W");
        end
    endgenerate

    logic [NUM_CH-1:0] wr_hit;

    fch_wr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .clk (clk), .rst_n (rst_n),
        .we  (snd_we), .ch (snd_ch), .hit (wr_hit)
    );

    fch_store #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_W(CH_W)) u_store (
        .clk (clk), .rst_n (rst_n),
        .wr_hit (wr_hit), .wr_data (snd_data),
        .rd_ch (rcv_rd_ch), .rd_data (rcv_rd_data)
    );

    fch_pending #(.NUM_CH(NUM_CH)) u_pend (
        .clk (clk), .rst_n (rst_n),
        .wr_hit (wr_hit), .clr (rcv_clr),
        .mask_we (rcv_mask_we), .mask_data (rcv_mask_data),
        .pend (rcv_pend), .ch_irq (rcv_ch_irq)
    );

    fch_group #(.NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP)) u_grp (
        .ch_irq (rcv_ch_irq), .grp_irq (rcv_grp_irq)
    );

    // An interrupt always needs a pending bit behind it.
    p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_ch_irq & ~rcv_pend) == '0);
    // No group fires while all channels are quiet.
    p_grp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_ch_irq == '0) |-> (rcv_grp_irq == '0));

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_grp_chk
            p_grp_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
                rcv_ch_irq[c] |-> rcv_grp_irq[c / GRP_SIZE]);
        end
    endgenerate
endmodule

// File: tb/sim_fch_bank.sv
`timescale 1ns/100ps
module sim_fch_bank;
    localparam int NCH  = 6;
    localparam int WW   = 64;
    localparam int GS   = 4;
    localparam int CW   = 3;
    localparam int NG   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_we = 1'b0;
    logic [CW-1:0] snd_ch = '0;
    logic [WW-1:0] snd_data = '0;
    logic [CW-1:0] rcv_rd_ch = '0;
    logic [WW-1:0] rcv_rd_data;
    logic [NCH-1:0] rcv_clr = '0;
    logic          rcv_mask_we = 1'b0;
    logic [NCH-1:0] rcv_mask_data = '0;
    logic [NCH-1:0] rcv_pend;
    logic [NCH-1:0] rcv_ch_irq;
    logic [NG-1:0]  rcv_grp_irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [WW-1:0]  m_word [NCH];
    logic [NCH-1:0] m_pend;
    logic [NCH-1:0] m_mask;

    always #5 clk = ~clk;

    fch_bank #(.NUM_CH(NCH), .WORD_W(WW), .GRP_SIZE(GS)) u0 (
        .clk (clk), .rst_n (rst_n),
        .snd_we (snd_we), .snd_ch (snd_ch), .snd_data (snd_data),
        .rcv_rd_ch (rcv_rd_ch), .rcv_rd_data (rcv_rd_data),
        .rcv_clr (rcv_clr), .rcv_mask_we (rcv_mask_we), .rcv_mask_data (rcv_mask_data),
        .rcv_pend (rcv_pend), .rcv_ch_irq (rcv_ch_irq), .rcv_grp_irq (rcv_grp_irq)
    );

    function automatic logic [NG-1:0] exp_grp(input logic [NCH-1:0] irq);
        logic [NG-1:0] r = '0;
        for (int c = 0; c < NCH; c++) if (irq[c]) r[c / GS] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every observable output with the model.
    task automatic check_all(input string ptag);
        for (int c = 0; c < 8; c++) begin
            rcv_rd_ch = CW'(c);
            #0.4;
            chk("R2 read", rcv_rd_data, (c < NCH) ? m_word[c] : '0);
        end
        chk(ptag, WW'(rcv_pend), WW'(m_pend));
        chk("R7 ch_irq", WW'(rcv_ch_irq), WW'(m_pend & ~m_mask));
        chk("R8 grp_irq", WW'(rcv_grp_irq), WW'(exp_grp(m_pend & ~m_mask)));
    endtask

    // One clock: update the model from the applied inputs, then check.
    task automatic step(input string ptag);
        @(posedge clk);
        if (!rst_n) begin
            m_pend = '0; m_mask = '0;
            for (int c = 0; c < NCH; c++) m_word[c] = '0;
        end else begin
            logic [NCH-1:0] hit = '0;
            if (snd_we && snd_ch < NCH) begin
                hit[snd_ch] = 1'b1;
                m_word[snd_ch] = snd_data;
            end
            m_pend = (m_pend & ~rcv_clr) | hit;
            if (rcv_mask_we) m_mask = rcv_mask_data;
        end
        #1;
        check_all(ptag);
        snd_we = 1'b0; rcv_clr = '0; rcv_mask_we = 1'b0;
    endtask

    task automatic wr(input int ch, input logic [WW-1:0] d);
        snd_we = 1'b1; snd_ch = CW'(ch); snd_data = d;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        step("R1 reset pend");
        step("R1 reset pend");
        rst_n = 1'b1;
        step("R1 idle pend");

        // R2/R4: plain write to channel 1.
        wr(1, 64'h1111_2222_3333_4444);
        step("R4 set");
        // R3: back-to-back overwrite, last wins.
        wr(1, 64'hAAAA_0000_0000_0001);
        step("R3 pend");
        wr(1, 64'hBBBB_0000_0000_0002);
        step("R3 pend");
        rcv_rd_ch = 3'd1; #0.4;
        chk("R3 last value", rcv_rd_data, 64'hBBBB_0000_0000_0002);
        chk("R3 pend held", WW'(rcv_pend[1]), WW'(1));
        // R5: clear channel 1, zero bits leave channel 5 alone.
        wr(5, 64'h5);
        step("R4 set");
        rcv_clr = 6'b000010;
        step("R5 clear");
        chk("R5 other kept", WW'(rcv_pend[5]), WW'(1));
        // R6: write and clear same channel same cycle.
        wr(4, 64'h4444);
        rcv_clr = 6'b010000;
        step("R6 collide");
        chk("R6 stays set", WW'(rcv_pend[4]), WW'(1));
        // R7: mask channel 4, then unmask with pending still set.
        rcv_mask_we = 1'b1; rcv_mask_data = 6'b010000;
        step("R7 mask");
        chk("R7 masked low", WW'(rcv_ch_irq[4]), WW'(0));
        rcv_mask_we = 1'b1; rcv_mask_data = 6'b000000;
        step("R7 unmask");
        chk("R7 unmasked high", WW'(rcv_ch_irq[4]), WW'(1));
        chk("R8 partial group", WW'(rcv_grp_irq[1]), WW'(1));
        // R9: out-of-range writes leave everything untouched.
        rcv_clr = '1;
        step("R5 clear all");
        wr(6, 64'hDEAD);
        step("R9 ignore");
        wr(7, 64'hBEEF);
        step("R9 ignore");
        chk("R9 no pending", WW'(rcv_pend), WW'(0));

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            snd_we = ($urandom % 2) == 0;
            snd_ch = CW'($urandom % 8);
            snd_data = {$urandom, $urandom};
            rcv_clr = (($urandom % 10) < 3) ? NCH'($urandom) : '0;
            rcv_mask_we = ($urandom % 20) == 0;
            rcv_mask_data = NCH'($urandom);
            step("R4 R5 random pend");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule